// File: doc/BRIEF.md
# Unsigned Multiplier with (4,2) Counter Reduction

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product, all in combinational logic with no clock. It first forms N partial-product rows, where row i is the multiplicand ANDed with multiplier bit i and shifted left by i columns. It then reduces those rows in levels. At each level, every group of four rows passes through a row of (4,2) counters and comes out as two rows. When two rows remain, a carry-propagate adder merges them into the product.

Each (4,2) counter is made of two full adders in series. It takes four bits of one weight and a lateral carry from the counter one column lower, and it has three outputs: a sum at its own weight, an external carry to the next level, and a lateral carry to the counter one column higher. The lateral carry depends only on the first three inputs. It therefore passes through one column and stops, so it cannot ripple along the row. At N=8 the tree has two levels (8 rows, then 4, then 2). At N=4 it has one level (4 rows, then 2).

Top module: `mul42_top`

## Requirements
- R1: A counter satisfies x1+x2+x3+x4+cin = sum + 2*(carry + cout) for all 32 input combinations.
- R2: A counter's lateral carry out (cout) is the majority of x1, x2 and x3 and never depends on cin.
- R3: A counter row over W columns keeps the column total: (r0+r1+r2+r3) mod 2^W = (s_row + c_row) mod 2^W. Here c_row bit k holds the external carry of column k-1, and c_row bit 0 is 0.
- R4: The lowest column of a row receives a lateral carry of 0, so s_row bit 0 is the XOR of the four bit-0 inputs.
- R5: At N=4 the product equals op_a*op_b for every one of the 256 operand pairs.
- R6: At N=8 the product equals op_a*op_b for arbitrary operand pairs.
- R7: A zero in either operand gives a zero product.
- R8: All-ones operands give the largest product, using the top product bit: 0xFE01 at N=8 and 0xE1 at N=4.
- R9: The product is combinational and settles within the same cycle as an operand change, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| product | output | 2N | Unsigned product op_a*op_b |

## Verification
A single counter can drive its lateral carry and its external carry high at the same time, and both then land on the same higher column, one in the current level and one in the next. To provoke this in every column, the bench drives all-ones operands and dense random operands, where four or five ones of equal weight occur often. The bench also drives the lone counter through all 32 input patterns, including the one with all inputs high, which sets sum, carry and cout together. The product is compared against an integer product computed in the bench, and the counter's outputs are compared against their arithmetic weight.

// File: rtl/mul42_pkg.sv
package mul42_pkg;

    typedef struct packed {
        logic sum;
        logic carry;
        logic cout;
    } cnt42_out_t;

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic c
);
    always_comb begin
        s = x ^ y ^ z;
        c = (x & y) | (x & z) | (y & z);
    end
endmodule

// File: rtl/cnt42.sv
module cnt42
    import mul42_pkg::*;
(
    input  logic       x1,
    input  logic       x2,
    input  logic       x3,
    input  logic       x4,
    input  logic       cin,
    output cnt42_out_t o
);
    logic mid_s;
    logic lat_c;
    logic fin_s;
    logic fin_c;

    // first adder: three equal-weight bits, its carry becomes the lateral output
    fa_cell u_fa_lo (.x(x1), .y(x2), .z(x3), .s(mid_s), .c(lat_c));
    // second adder: folds in the fourth bit and the neighbour's lateral carry
    fa_cell u_fa_hi (.x(mid_s), .y(x4), .z(cin), .s(fin_s), .c(fin_c));

    always_comb begin
        o.sum   = fin_s;
        o.carry = fin_c;
        o.cout  = lat_c;
    end

    always_comb begin
        AST_CNT_BALANCE: assert (({2'b0, x1} + {2'b0, x2} + {2'b0, x3} + {2'b0, x4} + {2'b0, cin})
                                 == ({2'b0, o.sum} + {1'b0, o.carry, 1'b0} + {1'b0, o.cout, 1'b0})); // R1
    end
endmodule

// File: rtl/cnt42_row.sv
module cnt42_row
    import mul42_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] r0,
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r2,
    input  logic [W-1:0] r3,
    output logic [W-1:0] s_row,
    output logic [W-1:0] c_row
);
    localparam int WX = W + 2;

    cnt42_out_t   co [W];
    logic [W:0]   lat;
    logic [W-1:0] carry_v;

    assign lat[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_col
        cnt42 u_cnt (
            .x1 (r0[k]),
            .x2 (r1[k]),
            .x3 (r2[k]),
            .x4 (r3[k]),
            .cin(lat[k]),
            .o  (co[k])
        );
        assign s_row[k]   = co[k].sum;
        assign carry_v[k] = co[k].carry;
        assign lat[k+1]   = co[k].cout;
    end

    // external carries move one column up; weight 2^W and above is dropped
    assign c_row = {carry_v[W-2:0], 1'b0};

    logic [WX-1:0] lhs_tot;
    logic [WX-1:0] rhs_tot;
    always_comb begin
        lhs_tot = WX'(r0) + WX'(r1) + WX'(r2) + WX'(r3);
        rhs_tot = WX'(s_row) + WX'({carry_v, 1'b0}) + WX'({lat[W], {W{1'b0}}});
        AST_ROW_CONSERVE: assert (lhs_tot == rhs_tot); // R3
        AST_ROW_BASE: assert (s_row[0] == (r0[0] ^ r1[0] ^ r2[0] ^ r3[0])); // R4
    end
endmodule

// File: rtl/pp_gen.sv
module pp_gen #(
    parameter int N = 8
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] pp [N]
);
    localparam int W = 2 * N;

    for (genvar i = 0; i < N; i++) begin : g_row
        assign pp[i] = W'({N{b[i]}} & a) << i;
    end

    logic [W-1:0] tot;
    always_comb begin
        tot = '0;
        for (int i = 0; i < N; i++) begin
            tot = tot + pp[i];
        end
        AST_PP_TOTAL: assert (tot == W'(a) * W'(b)); // R6
    end
endmodule

// File: rtl/cpa_adder.sv
module cpa_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    always_comb begin
        s = x + y;
    end
endmodule

// File: rtl/mul42_top.sv
module mul42_top #(
    parameter int N = 8
) (
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] product
);
    localparam int W      = 2 * N;
    localparam int LEVELS = $clog2(N) - 1;
    localparam int TOTAL  = 2 * N - 2;

    // every level stored back to back: level l starts at W - (W >> l)
    logic [W-1:0] rows    [TOTAL];
    logic [W-1:0] pp_rows [N];

    pp_gen #(.N(N)) u_pp (.a(op_a), .b(op_b), .pp(pp_rows));

    for (genvar i = 0; i < N; i++) begin : g_lvl0
        assign rows[i] = pp_rows[i];
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int IN_OFF  = W - (W >> l);
        localparam int OUT_OFF = W - (W >> (l + 1));
        localparam int GROUPS  = (N >> l) / 4;
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            cnt42_row #(.W(W)) u_row (
                .r0   (rows[IN_OFF + 4*g]),
                .r1   (rows[IN_OFF + 4*g + 1]),
                .r2   (rows[IN_OFF + 4*g + 2]),
                .r3   (rows[IN_OFF + 4*g + 3]),
                .s_row(rows[OUT_OFF + 2*g]),
                .c_row(rows[OUT_OFF + 2*g + 1])
            );
        end
    end

    cpa_adder #(.W(W)) u_cpa (.x(rows[TOTAL-2]), .y(rows[TOTAL-1]), .s(product));

    always_comb begin
        AST_PRODUCT_EXACT: assert (product == W'(op_a) * W'(op_b)); // R5
        if (op_a == '0 || op_b == '0) begin
            AST_ZERO_OPERAND: assert (product == '0); // R7
        end
        if (&op_a && &op_b) begin
            AST_ALL_ONES: assert (product == W'(W'({N{1'b1}}) * W'({N{1'b1}}))); // R8
        end
    end
endmodule

// File: tb/test_mul42_top.sv
`timescale 1ns/1ps
module test_mul42_top;
    import mul42_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 8x8 instance
    logic [7:0]  a8 = '0;
    logic [7:0]  b8 = '0;
    logic [15:0] p8;
    mul42_top #(.N(8)) i_mul42_top (.op_a(a8), .op_b(b8), .product(p8));

    // 4x4 instance
    logic [3:0] a4 = '0;
    logic [3:0] b4 = '0;
    logic [7:0] p4;
    mul42_top #(.N(4)) i_mul42_top_n4 (.op_a(a4), .op_b(b4), .product(p4));

    // lone counter
    logic x1 = 0, x2 = 0, x3 = 0, x4 = 0, ci = 0;
    cnt42_out_t cnt_o;
    cnt42 i_cnt42 (.x1(x1), .x2(x2), .x3(x3), .x4(x4), .cin(ci), .o(cnt_o));

    // lone counter row
    logic [7:0] q0 = '0, q1 = '0, q2 = '0, q3 = '0;
    logic [7:0] rs, rc;
    cnt42_row #(.W(8)) i_row (.r0(q0), .r1(q1), .r2(q2), .r3(q3), .s_row(rs), .c_row(rc));

    longint unsigned exp_q[$];

    task automatic drive_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R9 actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk("R7 reset zero 8x8", p8, 0);
        chk("R7 reset zero 4x4", p4, 0);

        // counter, all 32 patterns
        for (int v = 0; v < 32; v++) begin
            drive_edge();
            {x1, x2, x3, x4, ci} = v[4:0];
            @(negedge clk);
            chk("R1 counter weight", int'(cnt_o.sum) + 2 * (int'(cnt_o.carry) + int'(cnt_o.cout)),
                int'(x1) + int'(x2) + int'(x3) + int'(x4) + int'(ci));
            chk("R2 lateral carry majority", cnt_o.cout,
                ((int'(x1) + int'(x2) + int'(x3)) >= 2) ? 1 : 0);
        end

        // counter row, random rows
        for (int v = 0; v < 300; v++) begin
            drive_edge();
            q0 = 8'($urandom); q1 = 8'($urandom); q2 = 8'($urandom); q3 = 8'($urandom);
            if (v == 0) begin q0 = 8'hFF; q1 = 8'hFF; q2 = 8'hFF; q3 = 8'hFF; end
            @(negedge clk);
            chk("R3 row total", (longint'(rs) + longint'(rc)) % 256,
                (longint'(q0) + longint'(q1) + longint'(q2) + longint'(q3)) % 256);
            chk("R4 row base column", {rc[0], rs[0]}, {1'b0, q0[0] ^ q1[0] ^ q2[0] ^ q3[0]});
        end

        // 4x4 exhaustive
        for (int v = 0; v < 256; v++) begin
            drive_edge();
            a4 = 4'(v >> 4);
            b4 = 4'(v);
            @(negedge clk);
            chk("R5 4x4 product", p4, longint'(a4) * longint'(b4));
        end
        drive_edge();
        a4 = 4'hF; b4 = 4'hF;
        @(negedge clk);
        chk("R8 4x4 all ones", p4, 225);

        // 8x8 boundaries
        drive_edge();
        a8 = 8'hFF; b8 = 8'hFF;
        @(negedge clk);
        chk("R8 8x8 all ones", p8, 65025);
        drive_edge();
        a8 = 8'h00; b8 = 8'hFF;
        @(negedge clk);
        chk("R7 zero multiplicand", p8, 0);
        drive_edge();
        a8 = 8'hB7; b8 = 8'h00;
        @(negedge clk);
        chk("R7 zero multiplier", p8, 0);
        drive_edge();
        a8 = 8'h80; b8 = 8'h80;
        @(negedge clk);
        chk("R6 top bits", p8, 16384);
        drive_edge();
        a8 = 8'h01; b8 = 8'hFF;
        @(negedge clk);
        chk("R6 unit", p8, 255);

        // combinational settling: sampled 1 ns after the operand change
        @(posedge clk);
        #0.5;
        a8 = 8'hC3; b8 = 8'h5A;
        #1;
        chk("R9 same-cycle settle", p8, 195 * 90);

        // 8x8 random, reference through a queue
        for (int v = 0; v < 2000; v++) begin
            drive_edge();
            a8 = 8'($urandom);
            b8 = 8'($urandom);
            if (v % 7 == 0) a8 = a8 | 8'hF0;
            exp_q.push_back(longint'(a8) * longint'(b8));
            @(negedge clk);
            chk("R6 8x8 product", p8, exp_q.pop_front());
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule